// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from the encoder and decoder sub-blocks into a 32-bit sticky status register. Each source has a fixed bit position in that register. Software reads the status word, clears the bits it has handled by writing ones to them, and may inject status bits by writing to a separate set register. A mask register gates which status bits may drive the host interrupt. In the mask, a zero enables the bit and a one blocks it. The host sees one interrupt line. That line is the registered OR of every status bit whose mask bit is zero.

The register port is a simple single-cycle interface. A write is taken on the clock edge while `wr_en` is high. `rdata` shows, without delay, the register selected by `addr`. Byte offsets 0x40, 0x44 and 0x48 select status, set and mask.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, status reads 0x00000000, mask reads 0xFFFFFFFF and `irq` is 0.
- R2: A high `evt[k]` at a clock edge sets one fixed status bit at that edge. The mapping from k to bit is: 0→31 (encoder start capture), 1→30 (end of stream), 2→29 (VBI capture), 3→28 (video input reset), 4→27 (encoder DMA done), 5→24 (decoder audio mode change), 6→22 (decoder data request), 7→20 (decoder DMA done), 8→19 (VBI re-insertion), 9→18 (DMA linked-list error).
- R3: A status bit stays set until software clears it. A write of 1 to that bit at offset 0x40 is the only thing that clears it.
- R4: A write to offset 0x40 clears each status bit whose data bit is 1. Status bits whose data bit is 0 are left unchanged.
- R5: An event and a write-1-to-clear may hit the same status bit at the same edge. In that case the event wins and the bit stays set.
- R6: A write to offset 0x44 sets each status bit whose data bit is 1 and changes no other bit. Offset 0x44 always reads 0.
- R7: Offset 0x48 holds the mask. A write there replaces it, and it reads back as written.
- R8: `irq` equals the OR of (status AND NOT mask) as sampled at the previous clock edge.
- R9: Writes to any offset other than 0x40, 0x44 and 0x48 change no state, and such offsets read 0.
- R10: `rdata` shows the current value of the addressed register in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| evt | input | 10 | Event pulses, one per source |
| irq | output | 1 | Interrupt line to the host |

## Verification
Random sparse event patterns run together with random clears, set-register writes and mask writes. This shows whether each source reaches only its own bit and whether the sticky state survives unrelated writes. Random mask values, including all-ones and all-zeros, check the inverted polarity: enabled and blocked bits each decide `irq` on their own, one cycle late. Directed cases cover three points. The first is a clear and an event landing on the same bit, which tells event-priority apart from clear-priority. The second is writes to unmapped offsets, which tell a decoded write apart from a partially decoded one. The third is the set register reading zero, which shows it is write-only.

// File: rtl/irq_su_pkg.sv
package irq_su_pkg;
  localparam int NUM_SRC = 10;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 8;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_SET    = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h48;

  typedef enum logic [1:0] {SEL_NONE, SEL_STATUS, SEL_SET, SEL_MASK} reg_sel_e;

  // fixed status bit for each event source
  function automatic int src_bit_pos(input int k);
    case (k)
      0: return 31;
      1: return 30;
      2: return 29;
      3: return 28;
      4: return 27;
      5: return 24;
      6: return 22;
      7: return 20;
      8: return 19;
      default: return 18;
    endcase
  endfunction

  function automatic logic irq_pending(input logic [REG_W-1:0] st,
                                       input logic [REG_W-1:0] mk);
    return |(st & ~mk);
  endfunction

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_STATUS: return SEL_STATUS;
      OFS_SET:    return SEL_SET;
      OFS_MASK:   return SEL_MASK;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_event_map.sv
module irq_event_map
  import irq_su_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int W     = REG_W
) (
  input  logic [N_SRC-1:0] evt,
  output logic [W-1:0]     ev_bits
);
  always_comb begin
    ev_bits = '0;
    for (int k = 0; k < N_SRC; k++) begin
      ev_bits[src_bit_pos(k)] = ev_bits[src_bit_pos(k)] | evt[k];
    end
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_bits,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] status_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_bits) | set_bits | ev_bits;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '1;
    else if (we) mask_q <= wdata;
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_su_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int W     = REG_W,
  parameter int AW    = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  input  logic [N_SRC-1:0] evt,
  output logic             irq
);
  reg_sel_e   sel;
  logic [W-1:0] ev_bits, set_bits, clr_bits;
  logic [W-1:0] status_q, mask_q;
  logic         mask_we;
  logic         irq_q;

  assign sel      = decode_ofs(addr);
  assign set_bits = (wr_en && sel == SEL_SET)    ? wdata : '0;
  assign clr_bits = (wr_en && sel == SEL_STATUS) ? wdata : '0;
  assign mask_we  = wr_en && sel == SEL_MASK;

  irq_event_map #(.N_SRC(N_SRC), .W(W)) u_map (
    .evt(evt), .ev_bits(ev_bits)
  );

  irq_status_reg #(.W(W)) u_status (
    .clk(clk), .rst_n(rst_n), .ev_bits(ev_bits),
    .set_bits(set_bits), .clr_bits(clr_bits), .status_q(status_q)
  );

  irq_mask_reg #(.W(W)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(wdata), .mask_q(mask_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_pending(status_q, mask_q);
  end
  assign irq = irq_q;

  always_comb begin
    case (sel)
      SEL_STATUS: rdata = status_q;
      SEL_MASK:   rdata = mask_q;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] status_q,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] ev_bits,
  input logic [W-1:0] set_bits,
  input logic [W-1:0] clr_bits,
  input logic         mask_we,
  input logic         irq
);
  // R2
  status_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q)) & ~($past(ev_bits) | $past(set_bits))) == '0);

  // R3
  status_fall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~status_q & $past(status_q)) & ~$past(clr_bits)) == '0);

  // R5
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & $past(ev_bits)) == $past(ev_bits));

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask_q) |-> $past(mask_we));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |($past(status_q) & ~$past(mask_q)));
endmodule

bind irq_status_unit irq_status_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_q(status_q), .mask_q(mask_q),
  .ev_bits(ev_bits), .set_bits(set_bits), .clr_bits(clr_bits),
  .mask_we(mask_we), .irq(irq)
);

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [9:0]  evt = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] st_m, mk_m;
  logic        irq_m;
  bit          done = 0;

  irq_status_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt(evt), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] ev_to_bits(input logic [9:0] e);
    int pos[10] = '{31, 30, 29, 28, 27, 24, 22, 20, 19, 18};
    logic [31:0] b = '0;
    for (int k = 0; k < 10; k++) if (e[k]) b[pos[k]] = 1'b1;
    return b;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'h40) return st_m;
    if (a == 8'h48) return mk_m;
    return 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check read, advance model, check irq
  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic [9:0] e);
    wr_en = we; addr = a; wdata = d; evt = e;
    #1;
    check(rdata === model_read(a), "R10 read", rdata, model_read(a));
    irq_m = |(st_m & ~mk_m);
    if (we && a == 8'h40)      st_m = (st_m & ~d) | ev_to_bits(e);
    else if (we && a == 8'h44) st_m = st_m | d | ev_to_bits(e);
    else                       st_m = st_m | ev_to_bits(e);
    if (we && a == 8'h48) mk_m = d;
    @(posedge clk);
    @(negedge clk);
    check(irq === irq_m, "R8 irq", {31'b0, irq}, {31'b0, irq_m});
  endtask

  task automatic read_chk(input logic [7:0] a, input string req,
                          input logic [31:0] exp);
    wr_en = 1'b0; addr = a; evt = '0;
    #1;
    check(rdata === exp, req, rdata, exp);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs[4] = '{8'h40, 8'h44, 8'h48, 8'h4C};
    void'($urandom(32'd1234));
    st_m = '0; mk_m = '1; irq_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    read_chk(8'h40, "R1 status reset", 32'h0);
    read_chk(8'h48, "R1 mask reset", 32'hFFFF_FFFF);
    check(irq === 1'b0, "R1 irq reset", {31'b0, irq}, 32'h0);

    // R2 each source alone hits its own bit
    for (int k = 0; k < 10; k++) begin
      step(1'b0, 8'h40, '0, 10'(1) << k);
      read_chk(8'h40, "R2 event bit", ev_to_bits(10'(1) << k));
      step(1'b1, 8'h40, 32'hFFFF_FFFF, '0);
    end

    // R3 sticky across idle and unrelated clears
    step(1'b0, 8'h40, '0, 10'b00_0000_0001);
    step(1'b0, 8'h48, '0, '0);
    step(1'b1, 8'h40, 32'h0000_FFFF, '0);
    read_chk(8'h40, "R3 sticky", 32'h8000_0000);

    // R4 partial clear
    step(1'b1, 8'h44, 32'h0F0F_0F0F, '0);
    step(1'b1, 8'h40, 32'h0000_0F00, '0);
    read_chk(8'h40, "R4 w1c", 32'h8F0F_000F);
    step(1'b1, 8'h40, 32'hFFFF_FFFF, '0);

    // R5 event beats clear on same bit
    step(1'b0, 8'h40, '0, 10'b10_0000_0000);
    step(1'b1, 8'h40, 32'h0004_0000, 10'b10_0000_0000);
    read_chk(8'h40, "R5 event wins", 32'h0004_0000);
    step(1'b1, 8'h40, 32'hFFFF_FFFF, '0);

    // R6 set register: injects bits, zero data no effect, reads zero
    step(1'b1, 8'h44, 32'h0000_0003, '0);
    step(1'b1, 8'h44, 32'h0, '0);
    read_chk(8'h40, "R6 set inject", 32'h0000_0003);
    read_chk(8'h44, "R6 set reads zero", 32'h0);

    // R7 mask write and readback, then R8 gating
    step(1'b1, 8'h48, 32'hFFFF_FFFE, '0);
    read_chk(8'h48, "R7 mask readback", 32'hFFFF_FFFE);
    step(1'b0, 8'h40, '0, '0);
    check(irq === 1'b1, "R8 enabled bit", {31'b0, irq}, 32'h1);
    step(1'b1, 8'h48, 32'hFFFF_FFFF, '0);
    step(1'b0, 8'h40, '0, '0);
    check(irq === 1'b0, "R8 blocked bit", {31'b0, irq}, 32'h0);

    // R9 unmapped offsets
    step(1'b1, 8'h4C, 32'hFFFF_FFFF, '0);
    step(1'b1, 8'h00, 32'h0, '0);
    step(1'b1, 8'hC8, 32'h0, '0);
    read_chk(8'h40, "R9 status untouched", 32'h0000_0003);
    read_chk(8'h48, "R9 mask untouched", 32'hFFFF_FFFF);
    read_chk(8'h4C, "R9 unmapped reads zero", 32'h0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 5);
      logic [9:0]  e = 10'($urandom & $urandom & $urandom);
      logic [31:0] d = $urandom;
      if (op == 3 && $urandom_range(0, 3) == 0) d = ($urandom_range(0, 1) != 0) ? '1 : '0;
      case (op)
        0, 1: step(1'b0, addrs[$urandom_range(0, 3)], d, e);
        2:    step(1'b1, 8'h40, d, e);
        3:    step(1'b1, 8'h48, d, e);
        4:    step(1'b1, 8'h44, d & $urandom, e);
        default: step(1'b1, 8'h4C, d, e);
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule